// File: doc/BRIEF.md
# DMA channel event status and interrupt unit

This block gathers the completion and fault events of a group of DMA channel engines and turns them into software-visible state and one interrupt line. Every channel engine drives four single-cycle event pulses: transfer done, half done, fault and stopped. Each pulse latches a sticky bit in the status register for that event kind, at the bit position of the channel. Software reads these registers and clears bits by writing ones to them.

Each channel has a small control word holding its enable bit and four interrupt-suppress bits, one per event kind. The interrupt line is high when any status bit is set whose suppress bit is clear. A kill register sends one-cycle stop requests to any set of channels at once. An active register shows the enable bits of all channels. A global clear bit wipes all status and enable state in one cycle.

The register port is a plain single-cycle interface: a write takes effect at the clock edge where `reg_wr` is high, and a read returns its data on `reg_rdata` one cycle after `reg_rd`. The channel engines are outside this block.

Top module: `dma_evt_irq_unit`

## Requirements
- R1: After reset all four status registers, the active register, `ch_en`, `abort_req`, `irq` and `reg_rdata` read 0, and every channel control word reads 0x1E (enable 0, all four suppress bits 1).
- R2: An event pulse of kind k on channel i sets bit i of the status register at offset 1+k (kind 0 done, 1 half done, 2 fault, 3 stopped). It is visible to a read issued the next cycle and leaves all other status bits unchanged.
- R3: Writing a value to a status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Status bits are set whatever the suppress bits hold; a suppressed status bit never raises `irq`.
- R6: `irq` is registered: it goes high one cycle after a status bit with a clear suppress bit exists, and low one cycle after no such bit remains. The control word of channel c sits at offset 8+c with the enable in bit 0 and the suppress bit for kind k in bit 1+k.
- R7: Writing a bitmask to the kill register at offset 5 drives `abort_req` with that mask for exactly one cycle, starting the cycle after the write. The kill register reads 0.
- R8: Bit 0 of a channel control word is that channel's enable; `ch_en` and the active register at offset 6 show the enables of all channels.
- R9: A done, fault or stopped event on a channel clears its enable in the same edge; a half-done event does not.
- R10: Writing 1 to bit 0 of offset 0 clears all status bits and all enables at that edge, overriding events in the same cycle; suppress bits are kept.
- R11: `reg_rdata` changes only on the cycle after `reg_rd`; offsets 0, 5, 7 and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register offset, AW = clog2(8+NCH) |
| reg_wdata | input | DW | Write data, DW = max(NCH,5) |
| reg_rdata | output | DW | Read data, registered |
| ev_done | input | NCH | Transfer-done pulses, one per channel |
| ev_half | input | NCH | Half-done pulses |
| ev_fault | input | NCH | Fault pulses |
| ev_stop | input | NCH | Stopped pulses |
| ch_en | output | NCH | Channel enables |
| abort_req | output | NCH | One-cycle stop requests |
| irq | output | 1 | Combined interrupt, registered |

## Verification
A status bit, an enable change, the suppress bits and the kill mask all change at the edge that samples the event or the write, so they are read through the port one cycle after their stimulus and `abort_req` is sampled right after the write edge and again one edge later. `irq` has one more register, so every interrupt check samples it once right after the edge that changed the status or suppress bits (still old value) and again after the following edge. All inputs are driven on the falling edge and all outputs sampled on the falling edge, half a period clear of the active edge.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int NKIND = 4;
  localparam int CTRL_W = 1 + NKIND;

  typedef enum logic [1:0] {
    K_DONE  = 2'd0,
    K_HALF  = 2'd1,
    K_FAULT = 2'd2,
    K_STOP  = 2'd3
  } evt_kind_e;

  localparam int A_GCTL      = 0;
  localparam int A_STS0      = 1;
  localparam int A_KILL      = 5;
  localparam int A_ACTIVE    = 6;
  localparam int A_CTRL_BASE = 8;

  function automatic logic [CTRL_W-1:0] ctrl_word(input logic en, input logic [NKIND-1:0] sup);
    return {sup, en};
  endfunction
endpackage

// File: rtl/evt_bank.sv
module evt_bank #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           greset_i,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] q_o
);
  function automatic logic [NCH-1:0] sticky_next(input logic [NCH-1:0] cur,
                                                 input logic [NCH-1:0] set,
                                                 input logic [NCH-1:0] clr,
                                                 input logic wipe);
    if (wipe) return '0;
    return set | (cur & ~clr);
  endfunction

  logic [NCH-1:0] q_d;
  assign q_d = sticky_next(q_o, set_i, clr_i, greset_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!greset_i && (|set_i)) |=> ((q_o & $past(set_i)) == $past(set_i)));
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    !greset_i |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !greset_i |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i)));
  a_r10_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    greset_i |=> (q_o == '0));
endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl import dma_evt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              greset_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              term_i,
  output logic              en_o,
  output logic [NKIND-1:0]  sup_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o  <= 1'b0;
      sup_o <= '1;
    end else begin
      if (greset_i || term_i) en_o <= 1'b0;
      else if (wr_i)          en_o <= wdata_i[0];
      if (wr_i) sup_o <= wdata_i[CTRL_W-1:1];
    end
  end

  a_r9_term_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
    term_i |=> !en_o);
  a_r10_wipe_en: assert property (@(posedge clk) disable iff (!rst_n)
    greset_i |=> !en_o);
  a_r10_sup_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(sup_o));
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NCH = 8,
  parameter int NK  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NK-1:0][NCH-1:0] sts_i,
  input  logic [NK-1:0][NCH-1:0] sup_i,
  output logic                   irq_o
);
  function automatic logic any_pending(input logic [NK-1:0][NCH-1:0] s,
                                       input logic [NK-1:0][NCH-1:0] m);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NK; k++) r = r | (|(s[k] & ~m[k]));
    return r;
  endfunction

  logic pend;
  assign pend = any_pending(sts_i, sup_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend;
  end

  a_r6_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|sts_i));
  a_r5_all_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    (&sup_i) |=> !irq_o);
  a_r6_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_i == '0) |=> !irq_o);
endmodule

// File: rtl/dma_evt_irq_unit.sv
module dma_evt_irq_unit import dma_evt_pkg::*; #(
  parameter int NCH = 8,
  localparam int AW = $clog2(A_CTRL_BASE + NCH),
  localparam int DW = (NCH > CTRL_W) ? NCH : CTRL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NCH-1:0] ev_done,
  input  logic [NCH-1:0] ev_half,
  input  logic [NCH-1:0] ev_fault,
  input  logic [NCH-1:0] ev_stop,
  output logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] abort_req,
  output logic           irq
);
  logic gclr;
  logic kill_wr;
  logic [NKIND-1:0][NCH-1:0] ev_k, clr_k, sts_k, sup_k;
  logic [NCH-1:0][NKIND-1:0] sup_c;
  logic [DW-1:0] rd_next;

  assign gclr    = reg_wr && (reg_addr == AW'(A_GCTL)) && reg_wdata[0];
  assign kill_wr = reg_wr && (reg_addr == AW'(A_KILL));
  assign ev_k    = {ev_stop, ev_fault, ev_half, ev_done};

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign clr_k[k] = (reg_wr && (reg_addr == AW'(A_STS0 + k))) ? reg_wdata[NCH-1:0] : '0;
    evt_bank #(.NCH(NCH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .greset_i (gclr),
      .set_i    (ev_k[k]),
      .clr_i    (clr_k[k]),
      .q_o      (sts_k[k])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic wr_c, term_c;
    assign wr_c   = reg_wr && (reg_addr == AW'(A_CTRL_BASE + c));
    assign term_c = ev_done[c] | ev_fault[c] | ev_stop[c];
    chan_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .greset_i (gclr),
      .wr_i     (wr_c),
      .wdata_i  (reg_wdata[CTRL_W-1:0]),
      .term_i   (term_c),
      .en_o     (ch_en[c]),
      .sup_o    (sup_c[c])
    );
    for (genvar k = 0; k < NKIND; k++) begin : g_tr
      assign sup_k[k][c] = sup_c[c][k];
    end
  end

  irq_merge #(.NCH(NCH), .NK(NKIND)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .sts_i (sts_k),
    .sup_i (sup_k),
    .irq_o (irq)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr == AW'(A_ACTIVE)) rd_next = DW'(ch_en);
    for (int k = 0; k < NKIND; k++)
      if (reg_addr == AW'(A_STS0 + k)) rd_next = DW'(sts_k[k]);
    for (int c = 0; c < NCH; c++)
      if (reg_addr == AW'(A_CTRL_BASE + c)) rd_next = DW'(ctrl_word(ch_en[c], sup_c[c]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      abort_req <= '0;
    end else begin
      if (reg_rd) reg_rdata <= rd_next;
      abort_req <= kill_wr ? reg_wdata[NCH-1:0] : '0;
    end
  end

  a_r7_abort_follows: assert property (@(posedge clk) disable iff (!rst_n)
    kill_wr |=> (abort_req == $past(reg_wdata[NCH-1:0])));
  a_r7_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_wr) |=> (abort_req == '0));
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/dma_evt_irq_unit_tb.sv
module dma_evt_irq_unit_tb;
  localparam int NCH = 8;
  localparam int AW  = 4;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] ev_done = '0, ev_half = '0, ev_fault = '0, ev_stop = '0;
  logic [NCH-1:0] ch_en, abort_req;
  logic irq;

  int compared = 0, mismatched = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_evt_irq_unit #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_done(ev_done), .ev_half(ev_half), .ev_fault(ev_fault), .ev_stop(ev_stop),
    .ch_en(ch_en), .abort_req(abort_req), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    reg_rd = 1'b1; reg_addr = AW'(a);
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input int k, input logic [NCH-1:0] v);
    case (k)
      0: ev_done = v;
      1: ev_half = v;
      2: ev_fault = v;
      default: ev_stop = v;
    endcase
    tick();
    ev_done = '0; ev_half = '0; ev_fault = '0; ev_stop = '0;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) wr(1 + k, '1);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 abort_req", abort_req, 0);
    chk("R1 ch_en", ch_en, 0);
    chk("R1 rdata", reg_rdata, 0);
    for (int k = 0; k < 4; k++) begin rd(1 + k, d); chk("R1 status", d, 0); end
    rd(6, d); chk("R1 active", d, 0);
    rd(8, d); chk("R1 ctrl ch0", d, 8'h1E);
    rd(15, d); chk("R1 ctrl ch7", d, 8'h1E);
  endtask

  task automatic t_sticky();
    logic [DW-1:0] d;
    pulse(0, 8'h05);
    rd(1, d); chk("R2 done status", d, 8'h05);
    rd(2, d); chk("R2 half untouched", d, 0);
    pulse(2, 8'h80);
    rd(3, d); chk("R2 fault status", d, 8'h80);
    rd(1, d); chk("R2 done kept", d, 8'h05);
    pulse(1, 8'h40);
    rd(2, d); chk("R2 half status", d, 8'h40);
    pulse(3, 8'h01);
    rd(4, d); chk("R2 stop status", d, 8'h01);
  endtask

  task automatic t_w1c();
    logic [DW-1:0] d;
    wr(1, 8'h04); rd(1, d); chk("R3 clear one bit", d, 8'h01);
    wr(1, 8'h00); rd(1, d); chk("R3 zero write keeps", d, 8'h01);
    wr(1, 8'h01); rd(1, d); chk("R3 clear last", d, 8'h00);
    rd(3, d); chk("R3 other reg untouched", d, 8'h80);
    clear_all();
    rd(3, d); chk("R3 all cleared", d, 0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    pulse(1, 8'h04);
    ev_half = 8'h04; wr(2, 8'h04); ev_half = '0;
    rd(2, d); chk("R4 set beats clear", d, 8'h04);
    ev_half = 8'h08; wr(2, 8'h04); ev_half = '0;
    rd(2, d); chk("R4 clear other bit same cycle", d, 8'h08);
    clear_all();
  endtask

  task automatic t_mask_irq();
    logic [DW-1:0] d;
    pulse(3, 8'h02);
    chk("R5 suppressed edge1", irq, 0);
    tick(); chk("R5 suppressed edge2", irq, 0);
    rd(4, d); chk("R5 sticky while suppressed", d, 8'h02);
    wr(9, 8'h0E);
    chk("R6 irq not yet", irq, 0);
    tick(); chk("R6 irq after unmask", irq, 1);
    wr(4, 8'h02);
    chk("R6 irq still high", irq, 1);
    tick(); chk("R6 irq drops after clear", irq, 0);
    pulse(3, 8'h02);
    tick(); chk("R6 irq on new event", irq, 1);
    wr(9, 8'h1E);
    tick(); chk("R5 irq drops when suppressed", irq, 0);
    rd(9, d); chk("R6 ctrl readback", d, 8'h1E);
    clear_all();
  endtask

  task automatic t_abort();
    logic [DW-1:0] d;
    wr(5, 8'h81);
    chk("R7 abort mask", abort_req, 8'h81);
    tick(); chk("R7 abort one cycle", abort_req, 0);
    rd(5, d); chk("R7 kill reads zero", d, 0);
    wr(5, 8'h3C); chk("R7 second mask", abort_req, 8'h3C);
    tick(); chk("R7 second one cycle", abort_req, 0);
  endtask

  task automatic t_enable();
    logic [DW-1:0] d;
    wr(8, 8'h1F); wr(11, 8'h1F);
    rd(6, d); chk("R8 active reg", d, 8'h09);
    chk("R8 ch_en", ch_en, 8'h09);
    pulse(1, 8'h01);
    rd(6, d); chk("R9 half keeps enable", d, 8'h09);
    pulse(0, 8'h01);
    rd(6, d); chk("R9 done clears enable", d, 8'h08);
    pulse(2, 8'h08);
    chk("R9 fault clears enable", ch_en, 0);
    wr(11, 8'h1F);
    pulse(3, 8'h08);
    chk("R9 stop clears enable", ch_en, 0);
    rd(11, d); chk("R8 ctrl en bit", d, 8'h1E);
    clear_all();
  endtask

  task automatic t_greset();
    logic [DW-1:0] d;
    wr(10, 8'h1C); wr(12, 8'h1F);
    pulse(0, 8'h04);
    pulse(1, 8'h20);
    tick(); chk("R6 irq before global clear", irq, 1);
    chk("R8 ch4 enabled", ch_en, 8'h10);
    ev_fault = 8'h01; wr(0, 8'h01); ev_fault = '0;
    chk("R10 enables cleared", ch_en, 0);
    for (int k = 0; k < 4; k++) begin rd(1 + k, d); chk("R10 status cleared", d, 0); end
    chk("R10 irq low", irq, 0);
    rd(10, d); chk("R10 suppress kept", d, 8'h1C);
    rd(12, d); chk("R10 ch4 ctrl", d, 8'h1E);
    wr(10, 8'h1E);
  endtask

  task automatic t_read();
    logic [DW-1:0] d;
    pulse(0, 8'hFF);
    rd(7, d); chk("R11 unused offset", d, 0);
    rd(0, d); chk("R11 gctl reads zero", d, 0);
    rd(1, d); chk("R11 read status", d, 8'hFF);
    reg_addr = AW'(7);
    tick(); tick();
    chk("R11 rdata held", reg_rdata, 8'hFF);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_w1c();
    t_collide();
    t_mask_irq();
    t_abort();
    t_enable();
    t_greset();
    t_read();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule